// File: doc/BRIEF.md
# RC5 Key-Schedule Mixing Pipeline

This block performs the mixing phase of the RC5 key expansion for a stream of candidate keys, taking in one key per clock, as a key-search engine needs. Each key arrives with its starting S table (26 words by default) and its L words (the key loaded into words). The key then moves through a chain of identical stages, one mixing step per stage. Every stage carries the running A and B values, rewrites one S entry and one L word, and passes the results on.

The table is never stored whole for each key. An S entry rewritten by a stage is needed again exactly one table length later, so it travels to that stage through a shift-register delay line. The starting entries enter on skew lines. The final entries leave through deskew lines, so the whole mixed table and the L words appear together on one output beat. The stage count is a parameter, so a shorter chain can be built. Encryption and comparison with a target are not part of this block.

Both ends use valid/ready. A key is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. While a result is held back, the whole chain freezes and `in_ready` is low. `in_ready` never depends on `in_valid`.

Top module: `rc5_mix_pipe`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Each step forms the new S entry as (S + A + B) rotated left by 3 and makes that value the new A.
- R3: Each step then forms the new L word as (L + A + B), using the new A, rotated left by the low 5 bits of (A + B). That value becomes the new B.
- R4: Step k (k = 0 .. STAGES-1) uses S index k mod S_WORDS and L index k mod L_WORDS. A and B start at 0 for every key, and each key gets its own A and B.
- R5: A key accepted on an edge is presented on the outputs once STAGES advancing edges have occurred, that edge included. An edge advances the chain when `in_ready` is high.
- R6: While `out_ready` stays high, `in_ready` stays high and one key is accepted per clock. Results leave in acceptance order.
- R7: A cycle with `in_valid` low inserts a bubble. No result is produced for it and its data inputs are ignored.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid`, `out_s` and `out_l` hold. No key is lost or duplicated.
- R9: `out_s` word i (bits 32i+31..32i) is the last value written to S entry i. `out_l` word j is the last value written to L word j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid flags |
| in_valid | input | 1 | Starting table and key words are present |
| in_ready | output | 1 | Chain can advance; a key is taken when both are high |
| in_s | input | S_WORDS*32 | Starting S table, entry i in word i |
| in_l | input | L_WORDS*32 | Starting L words, word j in word j |
| out_valid | output | 1 | A mixed result is present |
| out_ready | input | 1 | Downstream takes the result |
| out_s | output | S_WORDS*32 | Mixed S table, entry i in word i |
| out_l | output | L_WORDS*32 | Mixed L words, word j in word j |

## Verification
Each result is due after exactly STAGES advancing edges, counted from the edge that accepted its key, and not after a fixed number of clocks. The bench counts advancing edges from `in_ready` and stamps every accepted key with that count. It checks that a result appears once the count reaches stamp plus STAGES and not before. It compares each result with a software model of the mixing phase. All ports are sampled two nanoseconds after a falling edge, so no reading races the rising edge.

// File: rtl/rc5_mix_pkg.sv
`timescale 1ns/1ps
package rc5_mix_pkg;
  parameter int WORD_W = 32;
  localparam int ROT_W = $clog2(WORD_W);
  localparam logic [ROT_W-1:0] S_ROT = ROT_W'(3);

  typedef logic [WORD_W-1:0] word_t;

  // left rotate by n: take upper half of the doubled word shifted left
  function automatic word_t rotl(word_t x, logic [ROT_W-1:0] n);
    logic [2*WORD_W-1:0] d;
    d = {x, x} << n;
    return d[2*WORD_W-1:WORD_W];
  endfunction
endpackage

// File: rtl/rc5_delay_line.sv
`timescale 1ns/1ps
module rc5_delay_line #(
  parameter int DEPTH = 1,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  assign dout = taps[DEPTH-1];

  // frozen chain keeps the line contents where they are
  assert_line_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));
endmodule

// File: rtl/rc5_mix_stage.sv
`timescale 1ns/1ps
module rc5_mix_stage
  import rc5_mix_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  in_valid,
  input  word_t a_in,
  input  word_t b_in,
  input  word_t s_in,
  input  word_t l_in,
  output logic  valid,
  output word_t a_out,
  output word_t b_out
);
  word_t sum_old, s_new, sum_new, l_new;

  always_comb begin
    sum_old = a_in + b_in;
    s_new   = rotl(s_in + sum_old, S_ROT);
    sum_new = s_new + b_in;
    l_new   = rotl(l_in + sum_new, sum_new[ROT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   valid <= 1'b0;
    else if (en)  valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      a_out <= s_new;
      b_out <= l_new;
    end
  end

  assert_valid_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> valid == $past(in_valid));

  assert_stage_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(valid) && $stable(a_out) && $stable(b_out));
endmodule

// File: rtl/rc5_mix_pipe.sv
`timescale 1ns/1ps
module rc5_mix_pipe
  import rc5_mix_pkg::*;
#(
  parameter int S_WORDS = 26,
  parameter int L_WORDS = 2,
  parameter int STAGES  = 78
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [S_WORDS-1:0][WORD_W-1:0]   in_s,
  input  logic [L_WORDS-1:0][WORD_W-1:0]   in_l,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [S_WORDS-1:0][WORD_W-1:0]   out_s,
  output logic [L_WORDS-1:0][WORD_W-1:0]   out_l
);
  localparam int S_LAG = S_WORDS - 1;
  localparam int L_LAG = L_WORDS - 1;
  localparam int FIRST_S_OUT = STAGES - S_WORDS;
  localparam int FIRST_L_OUT = STAGES - L_WORDS;

  logic  en;
  logic  st_v [STAGES];
  word_t st_a [STAGES];
  word_t st_b [STAGES];

  assign out_valid = st_v[STAGES-1];
  assign in_ready  = !out_valid || out_ready;
  assign en        = in_ready;

  for (genvar k = 0; k < STAGES; k++) begin : g_step
    word_t s_src, l_src, a_src, b_src;
    logic  v_src;

    // running A/B and valid come from the previous step
    if (k == 0) begin : g_head
      assign a_src = '0;
      assign b_src = '0;
      assign v_src = in_valid;
    end else begin : g_chain
      assign a_src = st_a[k-1];
      assign b_src = st_b[k-1];
      assign v_src = st_v[k-1];
    end

    // S entry: starting value on a skew line, or an earlier rewrite
    if (k == 0) begin : g_s0
      assign s_src = in_s[0];
    end else if (k < S_WORDS) begin : g_s_skew
      rc5_delay_line #(.DEPTH(k), .WIDTH(WORD_W)) u_skew (
        .clk(clk), .rst_n(rst_n), .en(en), .din(in_s[k]), .dout(s_src));
    end else begin : g_s_loop
      rc5_delay_line #(.DEPTH(S_LAG), .WIDTH(WORD_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .en(en), .din(st_a[k-S_WORDS]), .dout(s_src));
    end

    // L word: same scheme with the shorter L period
    if (k == 0) begin : g_l0
      assign l_src = in_l[0];
    end else if (k < L_WORDS) begin : g_l_skew
      rc5_delay_line #(.DEPTH(k), .WIDTH(WORD_W)) u_skew (
        .clk(clk), .rst_n(rst_n), .en(en), .din(in_l[k]), .dout(l_src));
    end else if (L_LAG == 0) begin : g_l_direct
      assign l_src = st_b[k-1];
    end else begin : g_l_loop
      rc5_delay_line #(.DEPTH(L_LAG), .WIDTH(WORD_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .en(en), .din(st_b[k-L_WORDS]), .dout(l_src));
    end

    rc5_mix_stage u_stage (
      .clk(clk), .rst_n(rst_n), .en(en), .in_valid(v_src),
      .a_in(a_src), .b_in(b_src), .s_in(s_src), .l_in(l_src),
      .valid(st_v[k]), .a_out(st_a[k]), .b_out(st_b[k]));

    // final writes of each S entry, aligned to the last step
    if (k >= FIRST_S_OUT) begin : g_s_out
      localparam int DS = STAGES - 1 - k;
      if (DS == 0) begin : g_now
        assign out_s[k % S_WORDS] = st_a[k];
      end else begin : g_late
        rc5_delay_line #(.DEPTH(DS), .WIDTH(WORD_W)) u_deskew (
          .clk(clk), .rst_n(rst_n), .en(en), .din(st_a[k]), .dout(out_s[k % S_WORDS]));
      end
    end

    if (k >= FIRST_L_OUT) begin : g_l_out
      localparam int DL = STAGES - 1 - k;
      if (DL == 0) begin : g_now
        assign out_l[k % L_WORDS] = st_b[k];
      end else begin : g_late
        rc5_delay_line #(.DEPTH(DL), .WIDTH(WORD_W)) u_deskew (
          .clk(clk), .rst_n(rst_n), .en(en), .din(st_b[k]), .dout(out_l[k % L_WORDS]));
      end
    end
  end

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_s) && $stable(out_l));

  assert_no_take_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/tb_rc5_mix_pipe.sv
`timescale 1ns/1ps
module tb_rc5_mix_pipe;
  localparam int T = 26;
  localparam int C = 2;
  localparam int N = 78;
  localparam int W = 32;

  typedef logic [T-1:0][W-1:0] stab_t;
  typedef logic [C-1:0][W-1:0] ltab_t;
  typedef struct { stab_t s; ltab_t l; int stamp; } exp_t;

  logic  clk = 1'b0;
  logic  rst_n, in_valid, in_ready, out_valid, out_ready;
  stab_t in_s, out_s;
  ltab_t in_l, out_l;

  exp_t q[$];
  int   checks = 0, errors = 0, adv_cnt = 0;
  bit   stall_mode = 1'b0;

  always #2.5 clk = ~clk;

  rc5_mix_pipe #(.S_WORDS(T), .L_WORDS(C), .STAGES(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_s(in_s), .in_l(in_l), .out_valid(out_valid), .out_ready(out_ready),
    .out_s(out_s), .out_l(out_l));

  function automatic logic [W-1:0] rot(logic [W-1:0] x, int n);
    if (n == 0) return x;
    return (x << n) | (x >> (W - n));
  endfunction

  // software model of the mixing phase (R2, R3, R4, R9)
  function automatic void model(input stab_t si, input ltab_t li,
                                output stab_t so, output ltab_t lo);
    logic [W-1:0] a = '0, b = '0, t;
    so = si; lo = li;
    for (int k = 0; k < N; k++) begin
      so[k % T] = rot(so[k % T] + a + b, 3);
      a = so[k % T];
      t = a + b;
      lo[k % C] = rot(lo[k % C] + t, int'(t[4:0]));
      b = lo[k % C];
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) adv_cnt <= 0;
    else if (in_ready) adv_cnt <= adv_cnt + 1;
  end

  always @(negedge clk) out_ready = stall_mode ? ($urandom_range(3) != 0) : 1'b1;

  task automatic offer(input bit v, input stab_t s, input ltab_t l);
    exp_t e;
    @(negedge clk);
    in_valid = v; in_s = s; in_l = l;
    #2;
    if (v && !stall_mode) begin
      checks++;
      if (!in_ready) begin
        errors++;
        $display("FAIL R6 in_ready act %0b exp 1", in_ready);
      end
    end
    while (v && !in_ready) begin
      @(negedge clk); #2;
    end
    if (v) begin
      model(s, l, e.s, e.l);
      e.stamp = adv_cnt;
      q.push_back(e);
    end
  endtask

  function automatic stab_t magic_s();
    stab_t s;
    s[0] = 32'hB7E15163;
    for (int i = 1; i < T; i++) s[i] = s[i-1] + 32'h9E3779B9;
    return s;
  endfunction

  function automatic stab_t rand_s();
    stab_t s;
    for (int i = 0; i < T; i++) s[i] = $urandom;
    return s;
  endfunction

  function automatic ltab_t rand_l();
    ltab_t l;
    for (int j = 0; j < C; j++) l[j] = $urandom;
    return l;
  endfunction

  // monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (out_valid) begin
          if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R7 out_valid act 1 exp 0 (no key pending)");
          end else begin
            checks++;
            if (adv_cnt != q[0].stamp + N) begin
              errors++;
              $display("FAIL R5 advance count act %0d exp %0d", adv_cnt, q[0].stamp + N);
            end
            if (out_ready) begin
              checks++;
              for (int i = 0; i < T; i++) begin
                if (out_s[i] !== q[0].s[i]) begin
                  errors++;
                  $display("FAIL R2 R4 R9 out_s[%0d] act %h exp %h", i, out_s[i], q[0].s[i]);
                  break;
                end
              end
              checks++;
              if (out_l !== q[0].l) begin
                errors++;
                $display("FAIL R3 R9 out_l act %h exp %h", out_l, q[0].l);
              end
              void'(q.pop_front());
            end else begin
              checks++;
              if (in_ready) begin
                errors++;
                $display("FAIL R8 in_ready act 1 exp 0");
              end
            end
          end
        end else if (q.size() > 0 && adv_cnt >= q[0].stamp + N) begin
          checks++; errors++;
          $display("FAIL R5 out_valid act 0 exp 1 at count %0d", adv_cnt);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_s = '0; in_l = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 out_valid act %0b exp 0", out_valid); end
    checks++;
    if (in_ready !== 1'b1) begin errors++; $display("FAIL R1 in_ready act %0b exp 1", in_ready); end

    // back-to-back stream, distinct patterns (R2 R3 R4 R6)
    offer(1'b1, '0, '0);
    offer(1'b1, '1, '1);
    offer(1'b1, magic_s(), '0);
    offer(1'b1, magic_s(), {32'h0, 32'h1});
    for (int n = 0; n < 10; n++) offer(1'b1, magic_s(), rand_l());
    offer(1'b1, rand_s(), rand_l());

    // bubbles carrying junk data (R7)
    for (int n = 0; n < 8; n++) begin
      offer(1'b0, rand_s(), rand_l());
      offer(1'b1, magic_s(), rand_l());
      if (n % 2 == 1) offer(1'b0, '1, '1);
    end

    // random back-pressure with bubbles (R8)
    stall_mode = 1'b1;
    for (int n = 0; n < 24; n++) begin
      offer(1'b1, (n % 3 == 0) ? rand_s() : magic_s(), rand_l());
      if (n % 4 == 0) offer(1'b0, rand_s(), rand_l());
    end
    offer(1'b0, '0, '0);
    repeat (200) @(negedge clk);
    stall_mode = 1'b0;

    while (q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule